// File: doc/BRIEF.md
# Start-of-Frame Symbol Detector and Sync Header Generator

This block sits between a symbol demodulator and the framing logic of a low-rate packet radio. On the receive side it watches a stream of 4-bit symbols and raises a single-cycle start-of-frame pulse once a programmable 16-bit sync word has arrived behind a run of zero symbols. A symbol whose value is all ones in any nibble of the sync word is a wildcard: that nibble is left out of the required sequence. One zero symbol is always required ahead of the first nibble that must match. The search only starts once the demodulator reports that its correlation has passed its threshold. After a match the detector stays quiet until the framing logic re-arms it.

On the transmit side the same sync word produces the symbols that open a frame. A programmable number of preamble bytes goes out as zero symbols, two per byte, and is followed by the sync-word nibbles, least significant first, with wildcard nibbles sent as zero. One symbol leaves per step strobe from the modulator.

Top module: `sfd_detector`

## Requirements
- R1: While reset is high and in the cycle after it falls, sfd_found, tx_active and tx_sym_valid are 0, and the detector waits for corr_ok before it examines any symbol.
- R2: Symbols are ignored until corr_ok has been sampled high; a corr_ok in cycle t makes symbols from cycle t+1 on count.
- R3: The required receive sequence is one zero symbol followed by the sync-word nibbles that are not 4'hF, taken from bits [3:0] upward; the default word 16'hA70F gives 0, 0, 7, A.
- R4: A nibble equal to 4'hF is left out of the sequence; word 16'hA7FF needs 0, 7, A, and 7, A without a leading zero does not match.
- R5: Word 16'hA700 needs 0, 0, 0, 7, A; only two zeros before 7, A do not match.
- R6: sfd_found is high for exactly one cycle, the cycle after the valid cycle of the last required symbol.
- R7: After a match no further pulse is raised until rearm; rearm has priority over every other input and returns the detector to waiting for corr_ok.
- R8: A nonzero symbol that breaks the sequence restarts the search from the start; a zero symbol that breaks it leaves the position at the smaller of the current zero run length and the number of leading zeros of the sequence, so extra preamble zeros are tolerated.
- R9: A cycle with sym_valid low does not advance or break the search, whatever sym_in holds.
- R10: tx_start while idle latches sync_word and preamble_len; each tx_step then emits one symbol with tx_sym_valid high in the next cycle: 2*preamble_len zeros, then the four sync nibbles from bits [3:0] upward with 4'hF sent as 0.
- R11: tx_active is high from the cycle after an accepted tx_start through the cycle before the last symbol appears; tx_start while active and tx_step while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rearm | input | 1 | Frame finished; return detector to waiting |
| corr_ok | input | 1 | Demodulator correlation above threshold |
| sym_valid | input | 1 | sym_in carries a received symbol |
| sym_in | input | 4 | Received symbol |
| sync_word | input | SYNC_W | Programmable sync word (default value 16'hA70F) |
| preamble_len | input | PRE_W | Preamble length in bytes for transmit |
| tx_start | input | 1 | Begin a transmit header |
| tx_step | input | 1 | Modulator requests next transmit symbol |
| sfd_found | output | 1 | One-cycle start-of-frame pulse |
| tx_active | output | 1 | Transmit header in progress |
| tx_sym_valid | output | 1 | tx_sym holds a new symbol |
| tx_sym | output | 4 | Transmit symbol |

## Verification
The assertions check on every cycle that a start-of-frame pulse lasts one cycle, follows a valid symbol, needs a prior corr_ok and occurs once per arming, and that transmit symbols are never all ones, follow a step while active and that an accepted start raises tx_active. Which symbol sequences do or do not produce a pulse for each sync word, the restart rule on zero and nonzero mismatches, the exact transmit order, and the rejection of starts while busy can only be shown by the bench's scenarios against its reference model.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int SYM_W = 4;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t WILD_SYM = '1;
    localparam sym_t ZERO_SYM = '0;

    typedef enum logic [1:0] {
        RX_WAIT   = 2'd0,
        RX_SEARCH = 2'd1,
        RX_FOUND  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic valid;
        sym_t sym;
    } sym_beat_t;

    // Wildcard nibbles go out as zero symbols.
    function automatic sym_t tx_map(sym_t s);
        return (s == WILD_SYM) ? ZERO_SYM : s;
    endfunction

    function automatic logic is_wild(sym_t s);
        return s == WILD_SYM;
    endfunction

endpackage

// File: rtl/sfd_pattern.sv
module sfd_pattern
    import sfd_pkg::*;
#(
    parameter int SYNC_W = 16,
    parameter int NIBS   = SYNC_W / SYM_W,
    parameter int MAXL   = NIBS + 1,
    parameter int LEN_W  = $clog2(MAXL + 1)
) (
    input  logic [SYNC_W-1:0]           sync_word,
    output logic [MAXL-1:0][SYM_W-1:0]  req,
    output logic [LEN_W-1:0]            req_len,
    output logic [LEN_W-1:0]            zlead
);

    sym_t nibs [NIBS];

    generate
        for (genvar g = 0; g < NIBS; g++) begin : g_nib
            assign nibs[g] = sync_word[g*SYM_W +: SYM_W];
        end
    endgenerate

    // Compact the non-wildcard nibbles behind one implicit zero.
    always_comb begin
        logic [LEN_W-1:0] cnt;
        req = '0;
        cnt = LEN_W'(1);
        for (int i = 0; i < NIBS; i++) begin
            if (!is_wild(nibs[i])) begin
                req[cnt] = nibs[i];
                cnt      = cnt + 1'b1;
            end
        end
        req_len = cnt;
    end

    // Count the zeros that open the required sequence.
    always_comb begin
        logic still;
        zlead = '0;
        still = 1'b1;
        for (int j = 0; j < MAXL; j++) begin
            if (still && (j < int'(req_len)) && (req[j] == ZERO_SYM)) begin
                zlead = zlead + 1'b1;
            end else begin
                still = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sfd_matcher.sv
module sfd_matcher
    import sfd_pkg::*;
#(
    parameter int MAXL  = 5,
    parameter int LEN_W = $clog2(MAXL + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rearm,
    input  logic                       corr_ok,
    input  sym_beat_t                  beat,
    input  logic [MAXL-1:0][SYM_W-1:0] req,
    input  logic [LEN_W-1:0]           req_len,
    input  logic [LEN_W-1:0]           zlead,
    output logic                       sfd_found
);

    rx_state_e        state_q;
    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] run_n;
    logic [LEN_W-1:0] fall_pos;
    logic             hit;
    logic             done;

    always_comb begin
        if (beat.sym != ZERO_SYM) begin
            run_n = '0;
        end else if (run_q == LEN_W'(MAXL)) begin
            run_n = run_q;
        end else begin
            run_n = run_q + 1'b1;
        end
        hit      = (beat.sym == req[pos_q]);
        done     = hit && ((pos_q + 1'b1) == req_len);
        fall_pos = (run_n < zlead) ? run_n : zlead;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_WAIT;
            pos_q     <= '0;
            run_q     <= '0;
            sfd_found <= 1'b0;
        end else begin
            sfd_found <= 1'b0;
            if (rearm) begin
                state_q <= RX_WAIT;
                pos_q   <= '0;
                run_q   <= '0;
            end else begin
                unique case (state_q)
                    RX_WAIT: begin
                        if (corr_ok) state_q <= RX_SEARCH;
                    end
                    RX_SEARCH: begin
                        if (beat.valid) begin
                            run_q <= run_n;
                            if (done) begin
                                state_q   <= RX_FOUND;
                                pos_q     <= '0;
                                sfd_found <= 1'b1;
                            end else if (hit) begin
                                pos_q <= pos_q + 1'b1;
                            end else if (beat.sym == ZERO_SYM) begin
                                pos_q <= fall_pos;
                            end else begin
                                pos_q <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sfd_txgen.sv
module sfd_txgen
    import sfd_pkg::*;
#(
    parameter int SYNC_W = 16,
    parameter int PRE_W  = 4,
    parameter int NIBS   = SYNC_W / SYM_W,
    parameter int MAXTOT = 2 * ((1 << PRE_W) - 1) + NIBS,
    parameter int TOT_W  = $clog2(MAXTOT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic              tx_step,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [PRE_W-1:0]  preamble_len,
    output logic              tx_active,
    output logic              tx_sym_valid,
    output sym_t              tx_sym
);

    logic [SYNC_W-1:0] sync_q;
    logic [TOT_W-1:0]  idx_q;
    logic [TOT_W-1:0]  pre_q;
    logic [TOT_W-1:0]  total_q;
    sym_t              tx_nibs [NIBS];
    sym_t              cur_sym;
    logic              last;

    generate
        for (genvar g = 0; g < NIBS; g++) begin : g_txnib
            assign tx_nibs[g] = tx_map(sync_q[g*SYM_W +: SYM_W]);
        end
    endgenerate

    always_comb begin
        cur_sym = ZERO_SYM;
        if (idx_q >= pre_q) begin
            for (int i = 0; i < NIBS; i++) begin
                if ((idx_q - pre_q) == TOT_W'(i)) cur_sym = tx_nibs[i];
            end
        end
        last = (idx_q == (total_q - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_active    <= 1'b0;
            tx_sym_valid <= 1'b0;
            tx_sym       <= ZERO_SYM;
            sync_q       <= '0;
            idx_q        <= '0;
            pre_q        <= '0;
            total_q      <= '0;
        end else begin
            tx_sym_valid <= 1'b0;
            if (!tx_active && tx_start) begin
                tx_active <= 1'b1;
                sync_q    <= sync_word;
                idx_q     <= '0;
                pre_q     <= TOT_W'({preamble_len, 1'b0});
                total_q   <= TOT_W'({preamble_len, 1'b0}) + TOT_W'(NIBS);
            end else if (tx_active && tx_step) begin
                tx_sym       <= cur_sym;
                tx_sym_valid <= 1'b1;
                idx_q        <= idx_q + 1'b1;
                if (last) tx_active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sfd_detector.sv
module sfd_detector
    import sfd_pkg::*;
#(
    parameter int SYNC_W = 16,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rearm,
    input  logic              corr_ok,
    input  logic              sym_valid,
    input  logic [3:0]        sym_in,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [PRE_W-1:0]  preamble_len,
    input  logic              tx_start,
    input  logic              tx_step,
    output logic              sfd_found,
    output logic              tx_active,
    output logic              tx_sym_valid,
    output logic [3:0]        tx_sym
);

    localparam int NIBS  = SYNC_W / SYM_W;
    localparam int MAXL  = NIBS + 1;
    localparam int LEN_W = $clog2(MAXL + 1);

    logic [MAXL-1:0][SYM_W-1:0] req;
    logic [LEN_W-1:0]           req_len;
    logic [LEN_W-1:0]           zlead;
    sym_beat_t                  beat;

    assign beat.valid = sym_valid;
    assign beat.sym   = sym_in;

    sfd_pattern #(
        .SYNC_W (SYNC_W),
        .NIBS   (NIBS),
        .MAXL   (MAXL),
        .LEN_W  (LEN_W)
    ) u_pattern (
        .sync_word (sync_word),
        .req       (req),
        .req_len   (req_len),
        .zlead     (zlead)
    );

    sfd_matcher #(
        .MAXL  (MAXL),
        .LEN_W (LEN_W)
    ) u_matcher (
        .clk       (clk),
        .rst       (rst),
        .rearm     (rearm),
        .corr_ok   (corr_ok),
        .beat      (beat),
        .req       (req),
        .req_len   (req_len),
        .zlead     (zlead),
        .sfd_found (sfd_found)
    );

    sfd_txgen #(
        .SYNC_W (SYNC_W),
        .PRE_W  (PRE_W)
    ) u_txgen (
        .clk          (clk),
        .rst          (rst),
        .tx_start     (tx_start),
        .tx_step      (tx_step),
        .sync_word    (sync_word),
        .preamble_len (preamble_len),
        .tx_active    (tx_active),
        .tx_sym_valid (tx_sym_valid),
        .tx_sym       (tx_sym)
    );

endmodule

// File: rtl/sfd_detector_chk.sv
module sfd_detector_chk (
    input logic       clk,
    input logic       rst,
    input logic       rearm,
    input logic       corr_ok,
    input logic       sym_valid,
    input logic       tx_start,
    input logic       tx_step,
    input logic       sfd_found,
    input logic       tx_active,
    input logic       tx_sym_valid,
    input logic [3:0] tx_sym
);

    logic seen_q;
    logic armed_q;
    logic got_q;

    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
        if (rst) begin
            armed_q <= 1'b0;
            got_q   <= 1'b0;
        end else begin
            if (rearm)        armed_q <= 1'b0;
            else if (corr_ok) armed_q <= 1'b1;
            if (rearm)          got_q <= 1'b0;
            else if (sfd_found) got_q <= 1'b1;
        end
    end

    // R1: quiet outputs right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (!sfd_found && !tx_active && !tx_sym_valid));

    // R2: a pulse needs corr_ok since the last rearm
    a_r2_needs_corr: assert property (@(posedge clk) disable iff (rst)
        sfd_found |-> $past(armed_q));

    // R6: one-cycle pulse, following a valid symbol
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sfd_found |=> !sfd_found);

    a_r6_after_symbol: assert property (@(posedge clk) disable iff (rst)
        sfd_found |-> $past(sym_valid));

    // R7: at most one pulse per arming
    a_r7_once_per_arm: assert property (@(posedge clk) disable iff (rst)
        sfd_found |-> !got_q);

    // R10: wildcard never transmitted; symbols paced by steps while active
    a_r10_no_wild: assert property (@(posedge clk) disable iff (rst)
        tx_sym_valid |-> (tx_sym != 4'hF));

    a_r10_paced: assert property (@(posedge clk) disable iff (rst)
        tx_sym_valid |-> ($past(tx_step) && $past(tx_active)));

    // R11: accepted start raises tx_active
    a_r11_start_raises: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && tx_start) |=> tx_active);

endmodule

bind sfd_detector sfd_detector_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rearm        (rearm),
    .corr_ok      (corr_ok),
    .sym_valid    (sym_valid),
    .tx_start     (tx_start),
    .tx_step      (tx_step),
    .sfd_found    (sfd_found),
    .tx_active    (tx_active),
    .tx_sym_valid (tx_sym_valid),
    .tx_sym       (tx_sym)
);

// File: tb/tb_sfd_detector.sv
module tb_sfd_detector;

    localparam time CYC = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rearm = 1'b0;
    logic        corr_ok = 1'b0;
    logic        sym_valid = 1'b0;
    logic [3:0]  sym_in = '0;
    logic [15:0] sync_word = 16'hA70F;
    logic [3:0]  preamble_len = '0;
    logic        tx_start = 1'b0;
    logic        tx_step = 1'b0;
    logic        sfd_found;
    logic        tx_active;
    logic        tx_sym_valid;
    logic [3:0]  tx_sym;

    always #(CYC/2) clk = ~clk;

    sfd_detector dut (
        .clk(clk), .rst(rst), .rearm(rearm), .corr_ok(corr_ok),
        .sym_valid(sym_valid), .sym_in(sym_in), .sync_word(sync_word),
        .preamble_len(preamble_len), .tx_start(tx_start), .tx_step(tx_step),
        .sfd_found(sfd_found), .tx_active(tx_active),
        .tx_sym_valid(tx_sym_valid), .tx_sym(tx_sym)
    );

    int vectors = 0;
    int miscompares = 0;
    int sfd_cnt = 0;
    bit finished = 0;

    // reference model state
    int m_state = 0, m_p = 0, m_run = 0;
    bit m_sfd = 0;
    int m_req[$];
    int m_z = 0;
    int q_tx[$];
    bit m_active = 0, m_valid = 0;
    int m_sym = 0;
    int got_tx[$];

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void build_req(logic [15:0] sw);
        m_req.delete();
        m_req.push_back(0);
        for (int i = 0; i < 4; i++) begin
            int n = (sw >> (4 * i)) & 15;
            if (n != 15) m_req.push_back(n);
        end
        m_z = 0;
        for (int i = 0; i < m_req.size(); i++) begin
            if (m_req[i] != 0) break;
            m_z++;
        end
    endfunction

    task automatic model_update();
        if (rst) begin
            m_state = 0; m_p = 0; m_run = 0; m_sfd = 0;
            q_tx.delete(); m_active = 0; m_valid = 0; m_sym = 0;
            return;
        end
        m_sfd = 0;
        if (rearm) begin
            m_state = 0; m_p = 0; m_run = 0;
        end else if (m_state == 0) begin
            if (corr_ok) m_state = 1;
        end else if (m_state == 1 && sym_valid) begin
            int s = sym_in;
            int rn = (s == 0) ? ((m_run + 1 > 5) ? 5 : m_run + 1) : 0;
            build_req(sync_word);
            if (s == m_req[m_p]) begin
                if (m_p + 1 == m_req.size()) begin
                    m_sfd = 1; m_state = 2; m_p = 0;
                end else m_p++;
            end else if (s == 0) m_p = (rn < m_z) ? rn : m_z;
            else m_p = 0;
            m_run = rn;
        end
        m_valid = 0;
        if (!m_active && tx_start) begin
            q_tx.delete();
            for (int i = 0; i < 2 * preamble_len; i++) q_tx.push_back(0);
            for (int i = 0; i < 4; i++) begin
                int n = (sync_word >> (4 * i)) & 15;
                q_tx.push_back(n == 15 ? 0 : n);
            end
            m_active = 1;
        end else if (m_active && tx_step) begin
            m_sym = q_tx.pop_front();
            m_valid = 1;
            if (q_tx.size() == 0) m_active = 0;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        if (finished) return;
        chk(sfd_found === m_sfd, "R6", "sfd_found model", sfd_found, m_sfd);
        chk(tx_active === m_active, "R11", "tx_active model", tx_active, m_active);
        chk(tx_sym_valid === m_valid, "R10", "tx_sym_valid model", tx_sym_valid, m_valid);
        if (m_valid) chk(tx_sym === m_sym[3:0], "R10", "tx_sym model", tx_sym, m_sym);
        if (sfd_found) sfd_cnt++;
        if (tx_sym_valid) got_tx.push_back(tx_sym);
    endtask

    task automatic send(int s);
        sym_valid = 1'b1; sym_in = s[3:0];
        step();
        sym_valid = 1'b0;
    endtask

    task automatic send_seq(int seq[$]);
        foreach (seq[i]) send(seq[i]);
    endtask

    task automatic arm(bit with_corr);
        rearm = 1'b1; step(); rearm = 1'b0;
        if (with_corr) begin corr_ok = 1'b1; step(); corr_ok = 1'b0; end
    endtask

    initial begin
        #(CYC * 150000);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int c0;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(sfd_found == 0, "R1", "sfd_found after reset", sfd_found, 0);
        chk(tx_active == 0, "R1", "tx_active after reset", tx_active, 0);
        chk(tx_sym_valid == 0, "R1", "tx_sym_valid after reset", tx_sym_valid, 0);

        // R2 no corr_ok yet: full pattern ignored
        c0 = sfd_cnt;
        send_seq('{0, 0, 7, 10});
        chk(sfd_cnt == c0, "R2", "pulses without corr_ok", sfd_cnt - c0, 0);

        // R3/R8/R9 default word, extra zeros and invalid cycles in between
        corr_ok = 1'b1; step(); corr_ok = 1'b0;
        send_seq('{0, 0, 0, 0});
        sym_valid = 1'b0; sym_in = 4'h5; step(); step();
        send(7);
        sym_in = 4'h3; step();
        send(10);
        chk(sfd_found == 1, "R3", "pulse after 0,0,7,A", sfd_found, 1);
        step();
        chk(sfd_found == 0, "R6", "pulse lasts one cycle", sfd_found, 0);

        // R7 no second pulse before rearm
        c0 = sfd_cnt;
        send_seq('{0, 0, 7, 10});
        chk(sfd_cnt == c0, "R7", "pulses while found", sfd_cnt - c0, 0);
        arm(0);
        send_seq('{0, 0, 7, 10});
        chk(sfd_cnt == c0, "R7", "pulses after rearm without corr", sfd_cnt - c0, 0);
        corr_ok = 1'b1; step(); corr_ok = 1'b0;
        send_seq('{0, 0, 7, 10});
        chk(sfd_cnt == c0 + 1, "R7", "pulses after rearm and corr", sfd_cnt - c0, 1);

        // R4 wildcards
        sync_word = 16'hA7FF;
        arm(1);
        c0 = sfd_cnt;
        send_seq('{5, 7, 10});
        chk(sfd_cnt == c0, "R4", "7,A without leading zero", sfd_cnt - c0, 0);
        send_seq('{0, 7, 10});
        chk(sfd_cnt == c0 + 1, "R4", "0,7,A with word A7FF", sfd_cnt - c0, 1);

        // R5 three zeros required
        sync_word = 16'hA700;
        arm(1);
        c0 = sfd_cnt;
        send_seq('{0, 0, 7, 10});
        chk(sfd_cnt == c0, "R5", "two zeros then 7,A", sfd_cnt - c0, 0);
        send_seq('{0, 0, 0, 7, 10});
        chk(sfd_cnt == c0 + 1, "R5", "three zeros then 7,A", sfd_cnt - c0, 1);

        // R8 restart rules
        sync_word = 16'hA70F;
        arm(1);
        c0 = sfd_cnt;
        send_seq('{0, 0, 7, 3, 10});
        chk(sfd_cnt == c0, "R8", "nonzero break", sfd_cnt - c0, 0);
        send_seq('{0, 0, 5, 0, 0, 7, 10});
        chk(sfd_cnt == c0 + 1, "R8", "recover after break", sfd_cnt - c0, 1);
        arm(1);
        send_seq('{0, 0, 0, 0, 0, 0, 0, 0, 7, 10});
        chk(sfd_cnt == c0 + 2, "R8", "long preamble", sfd_cnt - c0, 2);
        arm(1);
        send_seq('{0, 7, 0, 0, 7, 10});
        chk(sfd_cnt == c0 + 3, "R8", "zero after partial match", sfd_cnt - c0, 3);

        // R10/R11 transmit with preamble 2 bytes
        got_tx.delete();
        preamble_len = 4'd2; tx_start = 1'b1; step(); tx_start = 1'b0;
        chk(tx_active == 1, "R11", "active after start", tx_active, 1);
        preamble_len = 4'd7; sync_word = 16'h1234;
        tx_start = 1'b1; tx_step = 1'b1; step(); tx_start = 1'b0;
        for (int i = 0; i < 7; i++) begin
            tx_step = 1'b0; step(); tx_step = 1'b1; step();
        end
        tx_step = 1'b0; step();
        chk(got_tx.size() == 8, "R10", "header length", got_tx.size(), 8);
        if (got_tx.size() == 8) begin
            for (int i = 0; i < 6; i++) chk(got_tx[i] == 0, "R10", "preamble zero", got_tx[i], 0);
            chk(got_tx[6] == 7, "R10", "sync nibble 7", got_tx[6], 7);
            chk(got_tx[7] == 10, "R10", "sync nibble A", got_tx[7], 10);
        end
        chk(tx_active == 0, "R11", "idle after header", tx_active, 0);
        got_tx.delete();
        tx_step = 1'b1; step(); step(); tx_step = 1'b0; step();
        chk(got_tx.size() == 0, "R11", "step while idle", got_tx.size(), 0);

        // R10 zero preamble, wildcards sent as zero
        sync_word = 16'hF0F5; preamble_len = 4'd0;
        tx_start = 1'b1; step(); tx_start = 1'b0;
        tx_step = 1'b1; repeat (4) step(); tx_step = 1'b0; step();
        chk(got_tx.size() == 4, "R10", "short header length", got_tx.size(), 4);
        if (got_tx.size() == 4) begin
            chk(got_tx[0] == 5, "R10", "nibble 0", got_tx[0], 5);
            chk(got_tx[1] == 0, "R10", "wild nibble 1", got_tx[1], 0);
            chk(got_tx[2] == 0, "R10", "nibble 2", got_tx[2], 0);
            chk(got_tx[3] == 0, "R10", "wild nibble 3", got_tx[3], 0);
        end

        // mixed random traffic compared against the model every cycle (R3 R8 R9)
        begin
            logic [31:0] lf = 32'h1ACE_B00C;
            sync_word = 16'hA70F;
            arm(1);
            for (int n = 0; n < 3000; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                rearm = (lf[12:8] == 5'd0);
                corr_ok = lf[13];
                tx_start = (lf[20:17] == 4'd0);
                tx_step = lf[21];
                preamble_len = {2'b00, lf[23:22]};
                if (lf[26:24] == 3'd1) sync_word = {4'hA, lf[31:28], 4'h0, lf[27] ? 4'hF : 4'h0};
                case (lf[2:0])
                    3'd0, 3'd1, 3'd2, 3'd3: begin sym_valid = 1'b1; sym_in = 4'h0; end
                    3'd4: begin sym_valid = 1'b1; sym_in = 4'h7; end
                    3'd5: begin sym_valid = 1'b1; sym_in = 4'hA; end
                    3'd6: begin sym_valid = 1'b1; sym_in = lf[7:4]; end
                    default: begin sym_valid = 1'b0; sym_in = lf[7:4]; end
                endcase
                step();
            end
            rearm = 0; corr_ok = 0; tx_start = 0; tx_step = 0; sym_valid = 0;
            step();
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule